// File: doc/BRIEF.md
# Coprocessor Control and Semaphore Register Block

This block is the host-facing register set of a slave coprocessor. It keeps the run-control flags (halt, broke, single-step, interrupt-on-break) and eight general-purpose signal flags that host and coprocessor software use to talk to each other. No flag is written directly. A write to the status offset carries a clear bit and a set bit for each flag, and each flag resolves its own pair. This lets the host change one flag without a read-modify-write. The interrupt pair works the same way, but it stores nothing: it sends a one-cycle raise or lower request to the interrupt controller.

The block also contains a hardware semaphore and the coprocessor program counter. Reading the semaphore returns its current value and marks it taken, so a read of zero means the reader now owns it. Any write to the semaphore frees it. The program counter can be read at any time. It can be written only while the coprocessor is halted.

The host port is a single-cycle request with combinational read data. A read of the semaphore takes effect on the clock edge at the end of the access cycle.

Top module: `cop_ctrl_regs`

## Requirements
- R1: After reset, halt is 1. Broke, single-step, interrupt-on-break, all signal flags, the semaphore and the PC are 0. A status read then returns 0x00000001.
- R2: Write word layout at offset 0x10:
  - Bit pairs (clear, set): halt (0,1), single-step (5,6), interrupt-on-break (7,8), signal k (9+2k, 10+2k).
  - A write with only the clear bit of a pair set clears that flag at the next edge.
  - A write with only the set bit set sets it.
- R3: For any pair, a write with both bits set, or with neither set, leaves the flag unchanged.
- R4: Broke is set by a pulse on `break_i` and cleared by write bit 2. If both happen in the same cycle, `break_i` wins.
- R5: Write bits 3 (lower) and 4 (raise) drive `irq_lower_o` or `irq_raise_o` high for exactly the one cycle after the write. Both bits together, or neither, drive no request.
- R6: A status write whose halt pair is set-only pulses `step_clr_o` for one cycle, even if halt is already 1.
- R7: A read at offset 0x10 returns:
  - halt in bit 0 and broke in bit 1;
  - `dma_busy_i` in bit 2 and `dma_full_i` in bit 3;
  - single-step in bit 5 and interrupt-on-break in bit 6;
  - signals 0 to 7 in bits 7 to 14;
  - 0 in all other bits.
- R8: A read at offset 0x14 returns `dma_full_i` in bit 0 and 0 elsewhere. A read at 0x18, or at any unmapped offset, returns 0.
- R9: A read at offset 0x1C returns the semaphore (0 or 1) and sets it to 1 at the end of the access. Any write to 0x1C clears it.
- R10: With `pc_sel_i` set, a read returns the PC masked to 0xFFC. A write loads the PC only while halt is 1. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| pc_sel_i | input | 1 | Access targets the PC instead of the register window |
| addr_i | input | 5 | Byte offset within the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| dma_busy_i | input | 1 | DMA engine busy, shown in status |
| dma_full_i | input | 1 | DMA request queue full, shown in status |
| break_i | input | 1 | Coprocessor executed a break; sets broke |
| halt_o | output | 1 | Halt flag |
| single_step_o | output | 1 | Single-step flag |
| intr_on_break_o | output | 1 | Interrupt-on-break flag |
| signal_o | output | 8 | General signal flags |
| irq_raise_o | output | 1 | One-cycle raise request to the interrupt controller |
| irq_lower_o | output | 1 | One-cycle lower request to the interrupt controller |
| step_clr_o | output | 1 | One-cycle request to reset the coprocessor step counter |
| pc_o | output | 12 | Current program counter |

## Verification
The hardest case to reach is the "no change" outcome of a pair. It is only visible if the flag already holds the value the write would otherwise have forced. The bench therefore first sets single-step and a signal flag with set-only writes. It then issues both-bits and empty writes, and confirms through status reads that the flags kept their values. The PC gate needs a similar order: the bench loads the PC while halted, clears halt, and then attempts a second load. The semaphore is stepped through read-free, read-taken, release and read-free.

// File: rtl/cop_regs_pkg.sv
package cop_regs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned NUM_SIG = 8;
  localparam int unsigned PC_W = 12;

  localparam int unsigned OFS_STATUS = 'h10;
  localparam int unsigned OFS_FULL   = 'h14;
  localparam int unsigned OFS_ZERO   = 'h18;
  localparam int unsigned OFS_SEM    = 'h1C;

  // write-word bit positions
  localparam int unsigned WB_HALT_CLR  = 0;
  localparam int unsigned WB_HALT_SET  = 1;
  localparam int unsigned WB_BROKE_CLR = 2;
  localparam int unsigned WB_IRQ_CLR   = 3;
  localparam int unsigned WB_IRQ_SET   = 4;
  localparam int unsigned WB_SSTEP_CLR = 5;
  localparam int unsigned WB_SSTEP_SET = 6;
  localparam int unsigned WB_IOB_CLR   = 7;
  localparam int unsigned WB_IOB_SET   = 8;
  localparam int unsigned WB_SIG_BASE  = 9;

  // read-word bit positions
  localparam int unsigned RB_HALT     = 0;
  localparam int unsigned RB_BROKE    = 1;
  localparam int unsigned RB_BUSY     = 2;
  localparam int unsigned RB_FULL     = 3;
  localparam int unsigned RB_SSTEP    = 5;
  localparam int unsigned RB_IOB      = 6;
  localparam int unsigned RB_SIG_BASE = 7;

  typedef enum logic [1:0] {
    PAIR_HOLD = 2'd0,
    PAIR_CLR  = 2'd1,
    PAIR_SET  = 2'd2
  } pair_op_e;

  function automatic pair_op_e pair_resolve(input logic clr, input logic set);
    if (clr && !set) return PAIR_CLR;
    if (set && !clr) return PAIR_SET;
    return PAIR_HOLD;
  endfunction
endpackage

// File: rtl/cop_pair_flag.sv
module cop_pair_flag
  import cop_regs_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  pair_op_e op;
  assign op = wr_i ? pair_resolve(clr_i, set_i) : PAIR_HOLD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else if (op == PAIR_SET) q_o <= 1'b1;
    else if (op == PAIR_CLR) q_o <= 1'b0;
  end

  assert_pair_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && set_i && !clr_i) |=> q_o);
  assert_pair_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && clr_i && !set_i) |=> !q_o);
  assert_pair_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || (clr_i == set_i)) |=> $stable(q_o));
endmodule

// File: rtl/cop_sem.sv
module cop_sem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acq_i,
  input  logic rel_i,
  output logic taken_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taken_o <= 1'b0;
    else if (rel_i) taken_o <= 1'b0;
    else if (acq_i) taken_o <= 1'b1;
  end

  assert_sem_acq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq_i && !rel_i) |=> taken_o);
  assert_sem_rel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> !taken_o);
endmodule

// File: rtl/cop_pc_reg.sv
module cop_pc_reg #(
  parameter int unsigned PC_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            halt_i,
  input  logic [PC_W-1:0] wdata_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-3:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else if (wr_i && halt_i) word_q <= wdata_i[PC_W-1:2];
  end

  assign pc_o = {word_q, 2'b00};

  logic unused_low;
  assign unused_low = ^wdata_i[1:0];

  assert_pc_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !halt_i) |=> $stable(pc_o));
  assert_pc_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
  import cop_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              pc_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dma_busy_i,
  input  logic              dma_full_i,
  input  logic              break_i,
  output logic              halt_o,
  output logic              single_step_o,
  output logic              intr_on_break_o,
  output logic [NUM_SIG-1:0] signal_o,
  output logic              irq_raise_o,
  output logic              irq_lower_o,
  output logic              step_clr_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int unsigned NUM_PAIR = 3 + NUM_SIG;
  localparam int unsigned IDX_HALT = 0;
  localparam int unsigned IDX_SSTEP = 1;
  localparam int unsigned IDX_IOB = 2;

  logic win_wr, win_rd;
  logic hit_status, hit_full, hit_zero, hit_sem;
  assign win_wr = req_i && we_i && !pc_sel_i;
  assign win_rd = req_i && !we_i && !pc_sel_i;
  assign hit_status = addr_i == ADDR_W'(OFS_STATUS);
  assign hit_full   = addr_i == ADDR_W'(OFS_FULL);
  assign hit_zero   = addr_i == ADDR_W'(OFS_ZERO);
  assign hit_sem    = addr_i == ADDR_W'(OFS_SEM);

  logic st_wr;
  assign st_wr = win_wr && hit_status;

  // pair flags
  logic [NUM_PAIR-1:0] pr_clr, pr_set, pr_q;
  always_comb begin
    pr_clr[IDX_HALT]  = wdata_i[WB_HALT_CLR];
    pr_set[IDX_HALT]  = wdata_i[WB_HALT_SET];
    pr_clr[IDX_SSTEP] = wdata_i[WB_SSTEP_CLR];
    pr_set[IDX_SSTEP] = wdata_i[WB_SSTEP_SET];
    pr_clr[IDX_IOB]   = wdata_i[WB_IOB_CLR];
    pr_set[IDX_IOB]   = wdata_i[WB_IOB_SET];
    for (int k = 0; k < NUM_SIG; k++) begin
      pr_clr[3+k] = wdata_i[WB_SIG_BASE + 2*k];
      pr_set[3+k] = wdata_i[WB_SIG_BASE + 2*k + 1];
    end
  end

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    cop_pair_flag #(.RST_VAL(g == IDX_HALT)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (st_wr),
      .clr_i  (pr_clr[g]),
      .set_i  (pr_set[g]),
      .q_o    (pr_q[g])
    );
  end

  assign halt_o          = pr_q[IDX_HALT];
  assign single_step_o   = pr_q[IDX_SSTEP];
  assign intr_on_break_o = pr_q[IDX_IOB];
  assign signal_o        = pr_q[NUM_PAIR-1:3];

  // broke: hardware set has priority over host clear
  logic broke_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) broke_q <= 1'b0;
    else if (break_i) broke_q <= 1'b1;
    else if (st_wr && wdata_i[WB_BROKE_CLR]) broke_q <= 1'b0;
  end

  // request pulses
  pair_op_e irq_op;
  assign irq_op = st_wr ? pair_resolve(wdata_i[WB_IRQ_CLR], wdata_i[WB_IRQ_SET]) : PAIR_HOLD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_raise_o <= 1'b0;
      irq_lower_o <= 1'b0;
      step_clr_o  <= 1'b0;
    end else begin
      irq_raise_o <= irq_op == PAIR_SET;
      irq_lower_o <= irq_op == PAIR_CLR;
      step_clr_o  <= st_wr && wdata_i[WB_HALT_SET] && !wdata_i[WB_HALT_CLR];
    end
  end

  // semaphore
  logic sem_q;
  cop_sem u_sem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acq_i   (win_rd && hit_sem),
    .rel_i   (win_wr && hit_sem),
    .taken_o (sem_q)
  );

  // program counter
  cop_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_i && we_i && pc_sel_i),
    .halt_i  (halt_o),
    .wdata_i (wdata_i[PC_W-1:0]),
    .pc_o    (pc_o)
  );

  // read mux
  logic [DATA_W-1:0] status_word;
  always_comb begin
    status_word = '0;
    status_word[RB_HALT]  = halt_o;
    status_word[RB_BROKE] = broke_q;
    status_word[RB_BUSY]  = dma_busy_i;
    status_word[RB_FULL]  = dma_full_i;
    status_word[RB_SSTEP] = single_step_o;
    status_word[RB_IOB]   = intr_on_break_o;
    status_word[RB_SIG_BASE +: NUM_SIG] = signal_o;
  end

  always_comb begin
    rdata_o = '0;
    if (pc_sel_i) rdata_o[PC_W-1:0] = pc_o;
    else if (hit_status) rdata_o = status_word;
    else if (hit_full) rdata_o[0] = dma_full_i;
    else if (hit_sem) rdata_o[0] = sem_q;
    else if (hit_zero) rdata_o = '0;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assert_irq_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_raise_o && irq_lower_o));
  assert_irq_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_raise_o && !st_wr) |=> !irq_raise_o);
  assert_broke_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |=> (rdata_o[RB_BROKE] || pc_sel_i || !hit_status));
  assert_step_halt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_clr_o |-> halt_o);
endmodule

// File: tb/cop_ctrl_regs_bench.sv
module cop_ctrl_regs_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 0, we = 0, pc_sel = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic busy = 0, full = 0, brk = 0;
  logic halt, sstep, iob, raise, lower, stclr;
  logic [7:0] sig;
  logic [11:0] pc;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cop_ctrl_regs u_cop_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .pc_sel_i(pc_sel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .dma_busy_i(busy),
    .dma_full_i(full), .break_i(brk), .halt_o(halt), .single_step_o(sstep),
    .intr_on_break_o(iob), .signal_o(sig), .irq_raise_o(raise), .irq_lower_o(lower),
    .step_clr_o(stclr), .pc_o(pc)
  );

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", rq, got, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; pc_sel = p; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; pc_sel = 0; wdata = '0;
  endtask

  task automatic rd(input logic p, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; pc_sel = p; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 0; pc_sel = 0;
  endtask

  logic [31:0] r;

  task automatic t_reset;
    rd(0, 5'h10, r); chk("R1 status", r, 32'h1);
    rd(1, 5'h00, r); chk("R1 pc", r, 32'h0);
    chk("R1 sig", {24'h0, sig}, 32'h0);
    rd(0, 5'h1C, r); chk("R1 sem", r, 32'h0);
    wr(0, 5'h1C, 32'h0);
  endtask

  task automatic t_pairs;
    wr(0, 5'h10, (32'h1 << 6) | (32'h1 << 8) | (32'h1 << 10) | (32'h1 << 24));
    rd(0, 5'h10, r); chk("R2 set", r, 32'h1 | (1 << 5) | (1 << 6) | (1 << 7) | (1 << 14));
    chk("R2 sig_o", {24'h0, sig}, 32'h81);
    wr(0, 5'h10, 32'h1);
    chk("R2 halt clr", {31'h0, halt}, 32'h0);
    wr(0, 5'h10, 32'h1 << 23);
    chk("R2 sig7 clr", {24'h0, sig}, 32'h01);
  endtask

  task automatic t_hold;
    wr(0, 5'h10, (32'h3 << 5) | (32'h3 << 9));
    rd(0, 5'h10, r); chk("R3 both", r, (1 << 5) | (1 << 6) | (1 << 7));
    wr(0, 5'h10, 32'h0);
    rd(0, 5'h10, r); chk("R3 none", r, (1 << 5) | (1 << 6) | (1 << 7));
  endtask

  task automatic t_broke;
    @(negedge clk); brk = 1; @(negedge clk); brk = 0;
    rd(0, 5'h10, r); chk("R4 set", r & 32'h2, 32'h2);
    @(negedge clk); brk = 1; req = 1; we = 1; addr = 5'h10; wdata = 32'h4;
    @(negedge clk); brk = 0; req = 0; we = 0; wdata = 0;
    rd(0, 5'h10, r); chk("R4 prio", r & 32'h2, 32'h2);
    wr(0, 5'h10, 32'h4);
    rd(0, 5'h10, r); chk("R4 clr", r & 32'h2, 32'h0);
  endtask

  task automatic t_irq;
    wr(0, 5'h10, 32'h10);
    chk("R5 raise", {30'h0, raise, lower}, 32'h2);
    @(negedge clk); chk("R5 raise drop", {30'h0, raise, lower}, 32'h0);
    wr(0, 5'h10, 32'h08);
    chk("R5 lower", {30'h0, raise, lower}, 32'h1);
    wr(0, 5'h10, 32'h18);
    chk("R5 both", {30'h0, raise, lower}, 32'h0);
  endtask

  task automatic t_halt_step;
    wr(0, 5'h10, 32'h2);
    chk("R6 pulse", {30'h0, stclr, halt}, 32'h3);
    @(negedge clk); chk("R6 drop", {31'h0, stclr}, 32'h0);
    wr(0, 5'h10, 32'h2);
    chk("R6 again", {31'h0, stclr}, 32'h1);
  endtask

  task automatic t_dma;
    busy = 1; full = 1;
    rd(0, 5'h10, r); chk("R7 layout", r, 32'h1 | 32'hC | (1 << 5) | (1 << 6) | (1 << 7));
    rd(0, 5'h14, r); chk("R8 full", r, 32'h1);
    rd(0, 5'h18, r); chk("R8 zero", r, 32'h0);
    rd(0, 5'h04, r); chk("R8 unmapped", r, 32'h0);
    busy = 0; full = 0;
    rd(0, 5'h14, r); chk("R8 full0", r, 32'h0);
  endtask

  task automatic t_sem;
    rd(0, 5'h1C, r); chk("R9 free", r, 32'h0);
    rd(0, 5'h1C, r); chk("R9 taken", r, 32'h1);
    wr(0, 5'h1C, 32'h0);
    rd(0, 5'h1C, r); chk("R9 release", r, 32'h0);
    wr(0, 5'h1C, 32'h0);
  endtask

  task automatic t_pc;
    wr(1, 5'h00, 32'hFFFF_F123);
    rd(1, 5'h00, r); chk("R10 load", r, 32'h120);
    wr(0, 5'h10, 32'h1);
    wr(1, 5'h00, 32'h444);
    rd(1, 5'h00, r); chk("R10 gated", r, 32'h120);
    chk("R10 pc_o", {20'h0, pc}, 32'h120);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_pairs();
    t_hold();
    t_broke();
    t_irq();
    t_halt_step();
    t_dma();
    t_sem();
    t_pc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule